// File: doc/BRIEF.md
# Branch Source Trace Queue

This block keeps a short history of where the program last branched from. Each time the pipeline reports a taken branch while tracing is on, the block pushes the low 28 bits of the source instruction address into the newest slot of an eight-slot history. Every older slot moves one place deeper, and the oldest slot is discarded. Every slot carries a valid flag, which is set when an address lands in it.

Software reads a slot through a read-only port that returns a 32-bit word. A read strobe clears the valid flag of the slot it reads. With the default select value of zero, a read returns and consumes the most recent branch. The other select values let a debugger or a testbench inspect the deeper slots.

Writing the trace-enable control with the value 1 wipes every valid flag, so the history starts fresh. Power-on reset also clears the flags and turns tracing off. Reset does not touch the stored address bits.

Top module: `brtrace_queue`

## Requirements
- R1: `rd_data_o` shows the slot chosen by `rd_sel_i` in the same cycle. Slot 0 is the newest and slot 7 the oldest. Bit 31 is the slot's valid flag, bits 30 to 28 are zero, and bits 27 to 0 are the stored address bits 27 to 0.
- R2: A branch captured while tracing is on shifts every slot one place deeper after the next rising edge. Slot 0 then holds `br_addr_i`, and the former content of slot 7 is lost.
- R3: The slot that receives a captured address has its valid flag set to 1.
- R4: A read strobe clears the valid flag of the slot named by `rd_sel_i` at the next edge. All other flags and all addresses are left unchanged.
- R5: A write of the enable control with value 1 clears all valid flags at the next edge. A write with value 0 turns tracing off and keeps the flags. The new enable value governs captures from the following cycle on.
- R6: Power-on reset clears all valid flags and turns tracing off. Stored address bits keep their values through reset.
- R7: A branch strobe while tracing is off has no effect on any slot or flag.
- R8: When a capture and a read occur in the same cycle, the read clears the flag of the slot it read, and that slot then moves one place deeper. If the read was of slot 7, that slot is dropped. The new slot 0 is valid.
- R9: When an enable-on write and a capture occur in the same cycle while tracing is already on, all older flags are cleared and the new slot 0 is valid. If tracing was off, that same-cycle branch is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously and released synchronously inside the block |
| br_take_i | input | 1 | Taken-branch strobe, one cycle per branch |
| br_addr_i | input | 28 | Low address bits of the branch source instruction |
| trc_en_wr_i | input | 1 | Write strobe for the trace-enable control |
| trc_en_i | input | 1 | Value written to the trace-enable control |
| rd_stb_i | input | 1 | Read strobe; consumes the selected slot's flag |
| rd_sel_i | input | 3 | Slot to read, 0 = newest |
| rd_data_o | output | 32 | Read word: valid flag, zero bits, address |

## Verification
Read data is combinational from the select input, so the bench checks it in the same cycle, before the edge. Captures, flag clears and enable changes take effect at the next rising edge. Reset release reaches the logic after two more edges, through the internal synchronizer. The bench drives every input at the falling edge and updates its reference model at the rising edge. About half a nanosecond later it idles the strobes and sweeps the select input through all eight slots. It compares each slot's flag, zero bits and known address bits against the model, so every result is sampled one edge after the stimulus that caused it.

// File: rtl/brtq_pkg.sv
`timescale 1ns/1ps
package brtq_pkg;
  // Default geometry of the trace history.
  localparam int unsigned BRTQ_DEPTH = 8;   // number of history slots
  localparam int unsigned BRTQ_AW    = 28;  // stored address bits
  localparam int unsigned BRTQ_DW    = 32;  // read word width
  localparam int unsigned BRTQ_SYNC  = 2;   // reset release stages

  // Per-cycle update command for the history.
  typedef struct packed {
    logic cap;   // capture a branch this cycle
    logic wipe;  // clear all flags (enable set)
    logic rd;    // clear the selected flag
  } brtq_cmd_t;
endpackage

// File: rtl/brtq_rst_sync.sv
`timescale 1ns/1ps
module brtq_rst_sync #(
  parameter int unsigned STAGES = brtq_pkg::BRTQ_SYNC
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/brtq_enable_ctrl.sv
`timescale 1ns/1ps
module brtq_enable_ctrl (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic               en_i,
  input  logic               br_i,
  output logic               en_q_o,
  output brtq_pkg::brtq_cmd_t cmd_o,
  input  logic               rd_i
);
  logic en_q;
  logic en_d;

  // Next-state: a write replaces the enable; otherwise hold.
  always_comb begin
    en_d = en_q;
    if (wr_i) begin
      en_d = en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  // Capture uses the enable value held before this cycle's write.
  always_comb begin
    cmd_o.cap  = br_i & en_q;
    cmd_o.wipe = wr_i & en_i;
    cmd_o.rd   = rd_i;
  end

  assign en_q_o = en_q;
endmodule

// File: rtl/brtq_flag_queue.sv
`timescale 1ns/1ps
module brtq_flag_queue #(
  parameter  int unsigned DEPTH = brtq_pkg::BRTQ_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  brtq_pkg::brtq_cmd_t  cmd_i,
  input  logic [IDX_W-1:0]     sel_i,
  output logic [DEPTH-1:0]     flags_o
);
  logic [DEPTH-1:0] flags_q;
  logic [DEPTH-1:0] kept;
  logic [DEPTH-1:0] flags_d;
  logic [DEPTH-1:0] rd_mask;

  // One-hot mask of the slot being consumed by a read.
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_mask
      assign rd_mask[g] = cmd_i.rd && (sel_i == IDX_W'(g));
    end
  endgenerate

  // Clears act on the current contents; then the shift, if any.
  always_comb begin
    kept = flags_q & ~rd_mask;
    if (cmd_i.wipe) begin
      kept = '0;
    end
    flags_d = kept;
    if (cmd_i.cap) begin
      flags_d = {kept[DEPTH-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/brtq_addr_queue.sv
`timescale 1ns/1ps
module brtq_addr_queue #(
  parameter int unsigned DEPTH = brtq_pkg::BRTQ_DEPTH,
  parameter int unsigned AW    = brtq_pkg::BRTQ_AW
) (
  input  logic                     clk,
  input  logic                     cap_i,
  input  logic [AW-1:0]            addr_i,
  output logic [DEPTH-1:0][AW-1:0] addrs_o
);
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][AW-1:0] addr_in;

  // Address storage carries no reset; it only loads on a capture.
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      if (g == 0) begin : g_head
        assign addr_in[g] = addr_i;
      end else begin : g_body
        assign addr_in[g] = addr_q[g-1];
      end

      always_ff @(posedge clk) begin
        if (cap_i) begin
          addr_q[g] <= addr_in[g];
        end
      end
    end
  endgenerate

  assign addrs_o = addr_q;
endmodule

// File: rtl/brtq_read_port.sv
`timescale 1ns/1ps
module brtq_read_port #(
  parameter  int unsigned DEPTH = brtq_pkg::BRTQ_DEPTH,
  parameter  int unsigned AW    = brtq_pkg::BRTQ_AW,
  parameter  int unsigned DW    = brtq_pkg::BRTQ_DW,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]         sel_i,
  input  logic [DEPTH-1:0]         flags_i,
  input  logic [DEPTH-1:0][AW-1:0] addrs_i,
  output logic [DW-1:0]            data_o
);
  logic          sel_flag;
  logic [AW-1:0] sel_addr;

  always_comb begin
    sel_flag = 1'b0;
    sel_addr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel_i == IDX_W'(i)) begin
        sel_flag = flags_i[i];
        sel_addr = addrs_i[i];
      end
    end
  end

  // Flag on top, zero filler, address in the low bits.
  always_comb begin
    data_o           = '0;
    data_o[DW-1]     = sel_flag;
    data_o[AW-1:0]   = sel_addr;
  end
endmodule

// File: rtl/brtrace_queue.sv
`timescale 1ns/1ps
module brtrace_queue #(
  parameter  int unsigned DEPTH = brtq_pkg::BRTQ_DEPTH,
  parameter  int unsigned AW    = brtq_pkg::BRTQ_AW,
  parameter  int unsigned DW    = brtq_pkg::BRTQ_DW,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_take_i,
  input  logic [AW-1:0]    br_addr_i,
  input  logic             trc_en_wr_i,
  input  logic             trc_en_i,
  input  logic             rd_stb_i,
  input  logic [IDX_W-1:0] rd_sel_i,
  output logic [DW-1:0]    rd_data_o
);
  logic                     rst_sync_n;
  logic                     en_q;
  brtq_pkg::brtq_cmd_t      cmd;
  logic [DEPTH-1:0]         flags;
  logic [DEPTH-1:0][AW-1:0] addrs;

  brtq_rst_sync #(
    .STAGES (brtq_pkg::BRTQ_SYNC)
  ) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  brtq_enable_ctrl u_en (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_i   (trc_en_wr_i),
    .en_i   (trc_en_i),
    .br_i   (br_take_i),
    .en_q_o (en_q),
    .cmd_o  (cmd),
    .rd_i   (rd_stb_i)
  );

  brtq_flag_queue #(
    .DEPTH (DEPTH)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd_i   (cmd),
    .sel_i   (rd_sel_i),
    .flags_o (flags)
  );

  brtq_addr_queue #(
    .DEPTH (DEPTH),
    .AW    (AW)
  ) u_addr (
    .clk     (clk),
    .cap_i   (cmd.cap),
    .addr_i  (br_addr_i),
    .addrs_o (addrs)
  );

  brtq_read_port #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW)
  ) u_rd (
    .sel_i   (rd_sel_i),
    .flags_i (flags),
    .addrs_i (addrs),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/brtq_checker.sv
`timescale 1ns/1ps
module brtq_checker #(
  parameter  int unsigned DEPTH = brtq_pkg::BRTQ_DEPTH,
  parameter  int unsigned AW    = brtq_pkg::BRTQ_AW,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     br_take_i,
  input logic [AW-1:0]            br_addr_i,
  input logic                     trc_en_wr_i,
  input logic                     trc_en_i,
  input logic                     rd_stb_i,
  input logic [IDX_W-1:0]         rd_sel_i,
  input logic                     en_q,
  input logic [DEPTH-1:0]         flags,
  input logic [DEPTH-1:0][AW-1:0] addrs
);
  logic live_cap;
  assign live_cap = br_take_i && en_q;

  assert_newest_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    live_cap |=> flags[0]);

  assert_newest_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live_cap |=> addrs[0] == $past(br_addr_i));

  assert_deep_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live_cap |=> addrs[DEPTH-1] == $past(addrs[DEPTH-2]));

  assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !live_cap) |=> !flags[$past(rd_sel_i)]);

  assert_enable_wipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_en_wr_i && trc_en_i && !live_cap) |=> flags == '0);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !live_cap |=> $stable(addrs));

  assert_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cap && rd_stb_i && !trc_en_wr_i && rd_sel_i != IDX_W'(DEPTH-1))
      |=> (flags[0] && !flags[$past(rd_sel_i) + 1]));

  assert_reset_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flags == '0 && !en_q));
endmodule

bind brtrace_queue brtq_checker #(
  .DEPTH (DEPTH),
  .AW    (AW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .br_take_i   (br_take_i),
  .br_addr_i   (br_addr_i),
  .trc_en_wr_i (trc_en_wr_i),
  .trc_en_i    (trc_en_i),
  .rd_stb_i    (rd_stb_i),
  .rd_sel_i    (rd_sel_i),
  .en_q        (en_q),
  .flags       (flags),
  .addrs       (addrs)
);

// File: tb/brtrace_queue_bench.sv
`timescale 1ns/1ps
module brtrace_queue_bench;
  localparam int DEPTH = 8;
  localparam int AW    = 28;

  logic          clk;
  logic          rst_n;
  logic          br_take;
  logic [AW-1:0] br_addr;
  logic          en_wr;
  logic          en_val;
  logic          rd_stb;
  logic [2:0]    rd_sel;
  logic [31:0]   rd_data;

  int total;
  int bad;
  bit finished;

  // Reference model state.
  logic [AW-1:0] m_addr  [DEPTH];
  bit            m_val   [DEPTH];
  bit            m_known [DEPTH];
  bit            m_en;

  brtrace_queue u_brtrace_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_take_i   (br_take),
    .br_addr_i   (br_addr),
    .trc_en_wr_i (en_wr),
    .trc_en_i    (en_val),
    .rd_stb_i    (rd_stb),
    .rd_sel_i    (rd_sel),
    .rd_data_o   (rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word(input int s);
    return {m_val[s], 3'b000, m_addr[s]};
  endfunction

  // Model of one clock edge (R2..R9 semantics).
  task automatic model_edge(input bit br, input logic [AW-1:0] a, input bit wr,
                            input bit en, input bit rd, input int sel);
    bit cap;
    cap = br && m_en;
    if (rd) m_val[sel] = 0;
    if (wr && en) for (int i = 0; i < DEPTH; i++) m_val[i] = 0;
    if (cap) begin
      for (int i = DEPTH-1; i > 0; i--) begin
        m_val[i]   = m_val[i-1];
        m_addr[i]  = m_addr[i-1];
        m_known[i] = m_known[i-1];
      end
      m_val[0] = 1; m_addr[0] = a; m_known[0] = 1;
    end
    if (wr) m_en = en;
  endtask

  // Inspect every slot through the read port, with strobes idle.
  task automatic sweep(input string tag);
    for (int s = 0; s < DEPTH; s++) begin
      rd_sel = 3'(s);
      #0.1;
      chk(rd_data[31] == m_val[s], {tag, " flag"}, {31'b0, rd_data[31]}, {31'b0, m_val[s]});
      chk(rd_data[30:28] == 3'b000, "R1 zero bits", {29'b0, rd_data[30:28]}, 32'h0);
      if (m_known[s])
        chk(rd_data[AW-1:0] == m_addr[s], {tag, " addr"}, rd_data, exp_word(s));
    end
  endtask

  task automatic step(input bit br, input logic [AW-1:0] a, input bit wr, input bit en,
                      input bit rd, input int sel, input string tag);
    @(negedge clk);
    br_take = br; br_addr = a; en_wr = wr; en_val = en; rd_stb = rd; rd_sel = 3'(sel);
    #0.5;
    // R1: read word is valid in the same cycle as the select
    if (rd) begin
      chk(rd_data[31] == m_val[sel], "R1 live flag", rd_data, exp_word(sel));
      if (m_known[sel])
        chk(rd_data[AW-1:0] == m_addr[sel], "R1 live addr", rd_data, exp_word(sel));
    end
    @(posedge clk);
    model_edge(br, a, wr, en, rd, sel);
    #0.5;
    br_take = 0; en_wr = 0; rd_stb = 0;
    sweep(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    br_take = 0; en_wr = 0; rd_stb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) m_val[i] = 0;
    m_en = 0;
    #0.5;
    sweep("R6");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 0;
    rst_n = 0; br_take = 0; br_addr = '0; en_wr = 0; en_val = 0; rd_stb = 0; rd_sel = 0;
    for (int i = 0; i < DEPTH; i++) begin m_val[i] = 0; m_known[i] = 0; m_addr[i] = '0; end
    m_en = 0;
    void'($urandom(32'h5EED_0BE1));

    // R6: reset state
    do_reset();
    // R7: branch while tracing is off is ignored
    step(1, 28'h0AAAAAA, 0, 0, 0, 0, "R7");
    // R9: enable write with same-cycle branch while off, branch ignored
    step(1, 28'h0BBBBBB, 1, 1, 0, 0, "R9");
    // R2, R3: ten captures overflow the eight slots
    for (int k = 0; k < 10; k++) step(1, AW'(28'h1000000 + k * 28'h11111), 0, 0, 0, 0, "R2");
    // R4: consume newest and oldest
    step(0, '0, 0, 0, 1, 0, "R4");
    step(0, '0, 0, 0, 1, 7, "R4");
    step(0, '0, 0, 0, 1, 3, "R4");
    // R8: capture and read together
    step(1, 28'hC0FFEE1, 0, 0, 1, 0, "R8");
    step(1, 28'hC0FFEE2, 0, 0, 1, 7, "R8");
    step(1, 28'hC0FFEE3, 0, 0, 1, 4, "R8");
    // R9: enable-set write plus capture while already on
    step(1, 28'hFEDCBA9, 1, 1, 0, 0, "R9");
    // R5: disable keeps flags; R7: then branches ignored
    step(1, 28'h1234567, 0, 0, 0, 0, "R3");
    step(0, '0, 1, 0, 0, 0, "R5");
    step(1, 28'h7654321, 0, 0, 0, 0, "R7");
    step(0, '0, 1, 1, 0, 0, "R5");
    // Random mix
    for (int c = 0; c < 3000; c++) begin
      bit br, wr, en, rd;
      br = ($urandom % 2) == 0;
      wr = ($urandom % 20) == 0;
      en = ($urandom % 5) != 0;
      rd = ($urandom % 3) == 0;
      step(br, AW'($urandom), wr, en, rd, int'($urandom % DEPTH), "R2");
      if (c == 1500) do_reset();  // R6: addresses survive reset
      if (c == 1500) step(0, '0, 1, 1, 0, 0, "R5");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule